// File: doc/BRIEF.md
# Chopped Third-Order Sinc Decimator

This block turns the one-bit output stream of a sigma-delta modulator into signed conversion results. Each accepted bit counts as +1 when high and −1 when low. The block runs the bits through a cascade of three integrators and then three comb stages, and decimates by R = 8 × SF, where SF is an 8-bit filter word. It also drives a chop output that tells the analog front end to swap its input polarity.

The chop output toggles once per result. After each toggle the block throws away two decimated words while the filter settles, and keeps the third. When chop is high, the kept word is negated so that its sign is restored. It is then averaged with the kept word from the previous phase. Because of this, any offset that does not follow the chop polarity cancels out, and every result costs 3R accepted bits.

Both data edges use valid/ready handshakes. The input accepts one bit per cycle at most. While a result is held (`res_valid` high and `res_ready` low), the block deasserts `bit_ready`, so the whole filter stalls and no bit is lost. A result stays stable until it is taken. Changing SF or `chop_en` flushes the filter and the averaging history, and `bit_ready` is low during that flush cycle.

Top module: `chop_sinc3`

## Requirements
- R1: When reset is released, `res_valid` is low and `chop_out` is low.
- R2: A bit of 1 is integrated as +1 and a bit of 0 as −1. For periodic input whose period divides R, a settled decimated word equals R³ times the mean of the ±1 input.
- R3: After a flush, `chop_out` starts low and toggles at the clock edge that accepts every 3R-th bit. It changes at no other time, except that a flush clears it.
- R4: A kept word is negated if `chop_out` was high while its bits were accepted. The result is (previous kept word + new kept word), arithmetic shifted right by 11 (floor), and truncated to a 24-bit signed value.
- R5: An input that ignores `chop_out` (pure offset) produces results of 0.
- R6: After a flush, the first result is presented after the edge that accepts bit 6R. Each later result follows 3R accepted bits after the one before it.
- R7: A change of `sf` or `chop_en` flushes all filter state, the averaging history, the chop phase and any pending result. `bit_ready` is low in that cycle.
- R8: While `chop_en` is low, `bit_ready`, `chop_out` and `res_valid` stay low.
- R9: While `res_valid` is high and `res_ready` is low, `bit_ready` is low and `res_data` holds its value.
- R10: A value of `sf` below 13 acts as 13 (R = 104).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_valid | input | 1 | Modulator bit present |
| bit_ready | output | 1 | Bit accepted when high with bit_valid |
| bit_data | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| sf | input | 8 | Filter word; R = 8 × max(sf, 13) |
| chop_en | input | 1 | Enables chopped conversion |
| chop_out | output | 1 | Input polarity swap command |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_data | output | 24 | Signed averaged result |

## Verification
After a flush, the result for accepted bit 3R(k+2) is registered at the edge that accepts that bit. The bench counts handshakes itself, so it expects the k-th result exactly when its own count reaches that value. It samples one time unit after each edge, where it also checks that `chop_out` equals (count / 3R) mod 2. A result held under back-pressure is checked to keep both its value and the bit count frozen. The flush cycle is seen as a single cycle with no handshake before the count restarts.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef enum logic [1:0] {WD_A, WD_B, WD_C} widx_e;

  function automatic int acc_bits(int order, int ratio_max);
    return order * $clog2(ratio_max) + 1;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int W     = 34,
  parameter int ORDER = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] acc_nxt
);
  logic signed [W-1:0] acc [ORDER];
  logic signed [W-1:0] nxt [ORDER];

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign nxt[k] = acc[k] + x;
      end else begin : g_rest
        assign nxt[k] = acc[k] + nxt[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc[k] <= '0;
        else if (clr)    acc[k] <= '0;
        else if (en)     acc[k] <= nxt[k];
      end
    end
  endgenerate

  assign acc_nxt = nxt[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int W     = 34,
  parameter int ORDER = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] dly [ORDER];
  logic signed [W-1:0] stg [ORDER];

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stg[k] = din - dly[k];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   dly[k] <= '0;
          else if (clr) dly[k] <= '0;
          else if (en)  dly[k] <= din;
        end
      end else begin : g_rest
        assign stg[k] = stg[k-1] - dly[k];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   dly[k] <= '0;
          else if (clr) dly[k] <= '0;
          else if (en)  dly[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign dout = stg[ORDER-1];
endmodule

// File: rtl/chop_ctl.sv
module chop_ctl
  import sinc3_pkg::*;
#(
  parameter int W     = 34,
  parameter int OUT_W = 24,
  parameter int CNT_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 bit_acc,
  input  logic [CNT_W-1:0]     r_len,
  input  logic signed [W-1:0]  word,
  input  logic                 res_ready,
  output logic                 decim_evt,
  output logic                 chop_out,
  output logic                 res_valid,
  output logic [OUT_W-1:0]     res_data
);
  localparam int SHIFT = W + 1 - OUT_W;

  logic [CNT_W-1:0]    cnt;
  widx_e               widx;
  logic                chop_q;
  logic                have_prev;
  logic signed [W-1:0] prev_w;
  logic signed [W-1:0] corr;
  logic signed [W:0]   sum;
  logic                settled;

  assign decim_evt = bit_acc && (cnt == r_len - CNT_W'(1));
  assign settled   = decim_evt && (widx == WD_C);
  assign corr      = chop_q ? -word : word;
  assign sum       = {prev_w[W-1], prev_w} + {corr[W-1], corr};
  assign chop_out  = chop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; widx <= WD_A; chop_q <= 1'b0; have_prev <= 1'b0;
      prev_w <= '0; res_valid <= 1'b0; res_data <= '0;
    end else if (flush) begin
      cnt <= '0; widx <= WD_A; chop_q <= 1'b0; have_prev <= 1'b0;
      prev_w <= '0; res_valid <= 1'b0;
    end else begin
      if (bit_acc) cnt <= decim_evt ? '0 : cnt + CNT_W'(1);
      if (decim_evt) begin
        case (widx)
          WD_A:    widx <= WD_B;
          WD_B:    widx <= WD_C;
          default: begin
            widx      <= WD_A;
            chop_q    <= ~chop_q;
            prev_w    <= corr;
            have_prev <= 1'b1;
          end
        endcase
      end
      if (settled && have_prev) begin
        res_valid <= 1'b1;
        res_data  <= OUT_W'(sum >>> SHIFT);
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  // R9: a held result does not move
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !flush |=> res_valid && $stable(res_data));
  // R3: decimation counter stays inside the ratio
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> cnt < r_len);
  // R3: chop moves only on a kept word or a flush
  a_r3_chop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chop_out) |-> $past(settled) || $past(flush));
  // R6: a result needs two kept words
  a_r6_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(have_prev));
endmodule

// File: rtl/chop_sinc3.sv
module chop_sinc3
  import sinc3_pkg::*;
#(
  parameter int SF_W    = 8,
  parameter int SF_MIN  = 13,
  parameter int OSR_MUL = 8,
  parameter int ORDER   = 3,
  parameter int OUT_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_data,
  input  logic [SF_W-1:0]  sf,
  input  logic             chop_en,
  output logic             chop_out,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OUT_W-1:0] res_data
);
  localparam int OSR_SH = $clog2(OSR_MUL);
  localparam int CNT_W  = SF_W + OSR_SH;
  localparam int ACC_W  = acc_bits(ORDER, OSR_MUL * (2**SF_W - 1));

  logic [SF_W-1:0]      sf_q;
  logic                 en_q;
  logic                 flush;
  logic [SF_W-1:0]      sf_eff;
  logic [CNT_W-1:0]     r_len;
  logic                 bit_acc;
  logic                 decim_evt;
  logic signed [ACC_W-1:0] x;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= SF_W'(SF_MIN);
      en_q <= 1'b1;
    end else begin
      sf_q <= sf;
      en_q <= chop_en;
    end
  end

  assign flush     = (sf != sf_q) || (chop_en != en_q);
  assign sf_eff    = (sf < SF_W'(SF_MIN)) ? SF_W'(SF_MIN) : sf;
  assign r_len     = CNT_W'(sf_eff) << OSR_SH;
  assign bit_ready = chop_en && !flush && !(res_valid && !res_ready);
  assign bit_acc   = bit_valid && bit_ready;
  assign x         = bit_data ? ACC_W'(1) : {ACC_W{1'b1}};

  sinc3_integ #(.W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(flush), .en(bit_acc),
    .x(x), .acc_nxt(integ_out));

  sinc3_comb #(.W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(flush), .en(decim_evt),
    .din(integ_out), .dout(word));

  chop_ctl #(.W(ACC_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .bit_acc(bit_acc),
    .r_len(r_len), .word(word), .res_ready(res_ready),
    .decim_evt(decim_evt), .chop_out(chop_out),
    .res_valid(res_valid), .res_data(res_data));

  // R8: idle after chop is disabled
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_en && !en_q |-> !chop_out && !res_valid);
  // R7: a flush empties output and chop phase
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid && !chop_out);
endmodule

// File: tb/sim_chop_sinc3.sv
module sim_chop_sinc3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b1;
  logic        bit_data = 1'b0;
  logic [7:0]  sf = 8'd13;
  logic        chop_en = 1'b1;
  logic        res_ready = 1'b1;
  logic        bit_ready, chop_out, res_valid;
  logic [23:0] res_data;

  int checks = 0, errors = 0;
  int n = 0, rl = 104, pat = 1;
  bit chop_bad = 0, track = 0;

  chop_sinc3 u0 (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_data(bit_data), .sf(sf), .chop_en(chop_en),
    .chop_out(chop_out), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data));

  always #4 clk = ~clk;

  // rows: {sf, pattern}
  localparam logic [11:0] VEC [8] = '{
    {8'd13, 4'd1}, {8'd13, 4'd2}, {8'd13, 4'd0}, {8'd20, 4'd3},
    {8'd16, 4'd4}, {8'd24, 4'd5}, {8'd5,  4'd1}, {8'd0,  4'd2}};

  function automatic logic pat_bit(int p, int k, logic c);
    case (p)
      0: return 1'b1;
      1: return ~c;
      2: return c;
      3: return ((k % 4) != 3) ^ c;
      4: return ((k % 2) == 0) ^ c;
      default: return ((k % 4) != 3);
    endcase
  endfunction

  function automatic int pat_s(int p);
    case (p)
      1: return 4;
      2: return -4;
      3: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic longint expect_res(int r, int s);
    longint r3 = longint'(r) * r * r;
    return (r3 * s / 2) >>> 11;
  endfunction

  function automatic int ratio(int s);
    return 8 * ((s < 13) ? 13 : s);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit hs;
    bit_data = pat_bit(pat, n, chop_out);
    #1;
    hs = bit_valid && bit_ready;
    @(posedge clk); #1;
    if (hs) n++;
    if (track && (chop_out != (((n / (3 * rl)) % 2) == 1))) chop_bad = 1;
  endtask

  task automatic wait_res();
    int g = 0;
    while (!res_valid && g < 30000) begin step(); g++; end
  endtask

  task automatic start_row(int s, int p);
    track = 0;
    chop_en = 1'b0;
    step(); step();
    sf = 8'(s); pat = p; rl = ratio(s); chop_en = 1'b1;
    step();
    n = 0; chop_bad = 0; track = 1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check(!res_valid, "R1 res_valid", res_valid, 0);
    check(!chop_out, "R1 chop_out", chop_out, 0);

    // R8 disabled
    begin
      bit bad = 0;
      chop_en = 1'b0;
      step();
      for (int i = 0; i < 400; i++) begin
        step();
        if (bit_ready || chop_out || res_valid) bad = 1;
      end
      check(!bad, "R8 idle outputs", bad, 0);
    end

    // vector rows: R2 R4 R5 R6 R10 R3
    for (int v = 0; v < 8; v++) begin
      int s = int'(VEC[v][11:4]);
      int p = int'(VEC[v][3:0]);
      longint e = expect_res(ratio(s), pat_s(p));
      start_row(s, p);
      for (int k = 0; k < 3; k++) begin
        wait_res();
        check(n == 3 * rl * (k + 2), "R6/R10 result timing", n, 3 * rl * (k + 2));
        check(longint'($signed(res_data)) == e, (pat_s(p) == 0) ? "R5 offset cancel" : "R2/R4 value",
              longint'($signed(res_data)), e);
        step();
      end
      check(!chop_bad, "R3 chop toggle", chop_bad, 0);
    end

    // R9 back-pressure
    begin
      bit bad = 0;
      logic [23:0] held;
      int n0;
      longint e = expect_res(104, 4);
      start_row(13, 1);
      wait_res();
      res_ready = 1'b0;
      held = res_data; n0 = n;
      for (int i = 0; i < 20; i++) begin
        step();
        if (bit_ready || !res_valid || res_data != held) bad = 1;
      end
      check(!bad, "R9 stall hold", bad, 0);
      check(n == n0, "R9 no bits taken", n, n0);
      res_ready = 1'b1;
      step();
      wait_res();
      check(n == 9 * 104, "R9 timing after stall", n, 9 * 104);
      check(longint'($signed(res_data)) == e, "R9 value after stall", longint'($signed(res_data)), e);

      // R7 flush with a pending result
      res_ready = 1'b0;
      step();
      track = 0;
      sf = 8'd14; rl = ratio(14);
      step();
      check(!res_valid, "R7 pending dropped", res_valid, 0);
      check(!chop_out, "R7 chop cleared", chop_out, 0);
      res_ready = 1'b1;
      n = 0; chop_bad = 0; track = 1;
      e = expect_res(112, 4);
      wait_res();
      check(n == 6 * 112, "R7 first result after flush", n, 6 * 112);
      check(longint'($signed(res_data)) == e, "R7 value after flush", longint'($signed(res_data)), e);
      step();
      check(!chop_bad, "R3 chop after flush", chop_bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule